// File: doc/BRIEF.md
# Service-Link Port-Enable Register File

This block is the memory-mapped control register file of a serial service-link master. A host reaches it over a simple 32-bit bus with separate read and write strobes and byte addresses. The word index is the byte address with its two low bits dropped. The window holds 128 words (512 bytes). Indices at 128 or above read back as zero, and writes to them are dropped.

Two 32-bit port-enable words are the core of the block. Each one can be written three ways. One offset loads it outright. A second offset ORs the data into it. A third offset clears every bit that is set in the data. The set and clear offsets have no storage of their own, so they always read zero. An error-status word accepts writes but always reads zero, which signals that no errors are pending. A command word performs a full self-reset of the register state when either of its two top bits is written as one. A version word resets to 0xE0050101. Every other in-range word is plain storage.

Read data is registered, with one cycle of latency. A self-reset command is applied on the same clock edge as its write strobe, and it wins over everything else that edge would have done, including the read-data capture.

Top module: `psi_port_regs`

## Requirements
- R1: The word index is byte address bits [8:2], and address bits [1:0] are ignored. A byte address of 0x200 or above is out of range: it reads as zero and its write changes no register.
- R2: On an edge where the read strobe is high, the read data takes the value the addressed word held before that edge, even if the same edge writes that word. With the read strobe low, the read data holds its value.
- R3: A write to 0x010 or 0x014 loads port-enable word 0 or word 1 with the write data, and the word reads back at that same offset.
- R4: A write to 0x018 or 0x01C ORs the data into port-enable word 0 or word 1 respectively.
- R5: A write to 0x020 or 0x024 clears, in port-enable word 0 or word 1 respectively, each bit that is one in the data.
- R6: Offsets 0x018, 0x01C, 0x020 and 0x024 always read zero.
- R7: A write to the error-status word at 0x0D0 has no effect, and that word always reads zero.
- R8: A write to 0x1D0 with bit 31 or bit 30 set returns every register, and the read data, to its reset value on that same edge, ahead of any other update. A write to 0x1D0 with both of those bits clear changes nothing. Offset 0x1D0 reads zero.
- R9: After reset every word reads zero, except the version word at 0x074, which reads 0xE0050101.
- R10: A write to any other in-range offset, the version word included, stores the data verbatim, and a later read returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe, one word per high cycle |
| bus_waddr | input | 12 | Write byte address |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_raddr | input | 12 | Read byte address |
| bus_rdata | output | 32 | Registered read data, valid one cycle after the strobe |

## Verification
Reads and writes have separate addresses, so a read can share a clock edge with a write. Two such overlaps are driven on purpose. In the first, a read of a nonzero port-enable word is issued on the same edge as a self-reset command. The read data must come back zero, because the reset outranks the capture, and the version word must then read its reset value again. In the second, a read and a write target the same storage word on one edge. The read must return the old contents, and a following read must return the new data.

// File: rtl/psi_regs_pkg.sv
package psi_regs_pkg;

  // word indices whose behaviour differs from plain storage
  localparam int unsigned IDX_EN0  = 4;    // byte 0x010
  localparam int unsigned IDX_EN1  = 5;    // byte 0x014
  localparam int unsigned IDX_SET0 = 6;    // byte 0x018
  localparam int unsigned IDX_SET1 = 7;    // byte 0x01C
  localparam int unsigned IDX_CLR0 = 8;    // byte 0x020
  localparam int unsigned IDX_CLR1 = 9;    // byte 0x024
  localparam int unsigned IDX_VER  = 29;   // byte 0x074
  localparam int unsigned IDX_ERR  = 52;   // byte 0x0D0
  localparam int unsigned IDX_CMD  = 116;  // byte 0x1D0

  localparam int unsigned CMD_BIT_FULL = 31;
  localparam int unsigned CMD_BIT_ERR  = 30;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_STORE,
    OP_EN_LOAD,
    OP_EN_SET,
    OP_EN_CLR,
    OP_SELF_RST
  } wr_op_e;

endpackage

// File: rtl/psi_rst_sync.sv
module psi_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/psi_wr_decode.sv
module psi_wr_decode
  import psi_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BANK_W = 7
) (
  input  logic              wr,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  output wr_op_e            op,
  output logic              en_sel,
  output logic [BANK_W-1:0] widx
);
  logic in_range;

  assign widx     = waddr[BANK_W+1:2];
  assign in_range = (waddr[ADDR_W-1:BANK_W+2] == '0);

  always_comb begin
    op     = OP_NONE;
    en_sel = 1'b0;
    if (wr && in_range) begin
      if (widx == BANK_W'(IDX_EN0) || widx == BANK_W'(IDX_EN1)) begin
        op     = OP_EN_LOAD;
        en_sel = (widx == BANK_W'(IDX_EN1));
      end else if (widx == BANK_W'(IDX_SET0) || widx == BANK_W'(IDX_SET1)) begin
        op     = OP_EN_SET;
        en_sel = (widx == BANK_W'(IDX_SET1));
      end else if (widx == BANK_W'(IDX_CLR0) || widx == BANK_W'(IDX_CLR1)) begin
        op     = OP_EN_CLR;
        en_sel = (widx == BANK_W'(IDX_CLR1));
      end else if (widx == BANK_W'(IDX_CMD)) begin
        if (wdata[CMD_BIT_FULL] || wdata[CMD_BIT_ERR]) op = OP_SELF_RST;
      end else if (widx != BANK_W'(IDX_ERR)) begin
        op = OP_STORE;
      end
    end
  end
endmodule

// File: rtl/psi_en_reg.sv
module psi_en_reg #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              load,
  input  logic              set,
  input  logic              clr,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] q_d;
  logic              q_en;

  always_comb begin
    q_en = soft_clr | load | set | clr;
    q_d  = q;
    if (soft_clr)  q_d = '0;
    else if (load) q_d = d;
    else if (set)  q_d = q | d;
    else if (clr)  q_d = q & ~d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (q_en) q <= q_d;
  end

  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    load && !soft_clr |=> q == $past(d));
  a_r4_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    set && !soft_clr |=> ((q & $past(d)) == $past(d)) &&
                         ((q & ~$past(d)) == ($past(q) & ~$past(d))));
  a_r5_clr_bits: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !soft_clr |=> ((q & $past(d)) == '0) &&
                         ((q & ~$past(d)) == ($past(q) & ~$past(d))));
endmodule

// File: rtl/psi_store_bank.sv
module psi_store_bank #(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 128,
  parameter int unsigned VER_IDX   = 29,
  parameter logic [DATA_W-1:0] VER_RST = 32'hE005_0101,
  localparam int unsigned BANK_W   = $clog2(NUM_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_clr,
  input  logic              we,
  input  logic [BANK_W-1:0] widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [BANK_W-1:0] ridx,
  output logic [DATA_W-1:0] rword
);
  logic [DATA_W-1:0] mem_q [NUM_WORDS];
  logic [DATA_W-1:0] mem_d [NUM_WORDS];
  logic              mem_en;

  function automatic logic [DATA_W-1:0] rst_val(input int unsigned i);
    return (i == VER_IDX) ? VER_RST : '0;
  endfunction

  always_comb begin
    mem_en = soft_clr | we;
    for (int i = 0; i < NUM_WORDS; i++) begin
      if (soft_clr)                     mem_d[i] = rst_val(i);
      else if (we && widx == BANK_W'(i)) mem_d[i] = wdata;
      else                              mem_d[i] = mem_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= rst_val(i);
    end else if (mem_en) begin
      for (int i = 0; i < NUM_WORDS; i++) mem_q[i] <= mem_d[i];
    end
  end

  assign rword = mem_q[ridx];

  a_r10_store: assert property (@(posedge clk) disable iff (!rst_n)
    we && !soft_clr |=> mem_q[$past(widx)] == $past(wdata));
  a_r9_ver_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
    soft_clr |=> mem_q[VER_IDX] == VER_RST);
endmodule

// File: rtl/psi_port_regs.sv
module psi_port_regs
  import psi_regs_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned NUM_WORDS = 128,
  parameter logic [DATA_W-1:0] VER_RST = 32'hE005_0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_waddr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_raddr,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int unsigned BANK_W = $clog2(NUM_WORDS);
  localparam int unsigned NUM_EN = 2;

  logic                           rst_i_n;
  wr_op_e                         op;
  logic                           en_sel;
  logic [BANK_W-1:0]              widx;
  logic                           soft_clr;
  logic [NUM_EN-1:0][DATA_W-1:0]  en_q;
  logic [BANK_W-1:0]              ridx;
  logic                           rd_in_range;
  logic [DATA_W-1:0]              bank_word;
  logic [DATA_W-1:0]              rd_d;
  logic                           rd_en;

  psi_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  psi_wr_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BANK_W(BANK_W)) u_dec (
    .wr(bus_wr), .waddr(bus_waddr), .wdata(bus_wdata),
    .op(op), .en_sel(en_sel), .widx(widx)
  );

  assign soft_clr = (op == OP_SELF_RST);

  for (genvar g = 0; g < NUM_EN; g++) begin : g_en
    logic hit;
    assign hit = (en_sel == 1'(g));
    psi_en_reg #(.DATA_W(DATA_W)) u_en (
      .clk(clk), .rst_n(rst_i_n), .soft_clr(soft_clr),
      .load(hit && op == OP_EN_LOAD),
      .set (hit && op == OP_EN_SET),
      .clr (hit && op == OP_EN_CLR),
      .d(bus_wdata), .q(en_q[g])
    );
  end

  assign ridx        = bus_raddr[BANK_W+1:2];
  assign rd_in_range = (bus_raddr[ADDR_W-1:BANK_W+2] == '0);

  psi_store_bank #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS),
                   .VER_IDX(IDX_VER), .VER_RST(VER_RST)) u_bank (
    .clk(clk), .rst_n(rst_i_n), .soft_clr(soft_clr),
    .we(op == OP_STORE), .widx(widx), .wdata(bus_wdata),
    .ridx(ridx), .rword(bank_word)
  );

  always_comb begin
    rd_en = soft_clr | bus_rd;
    rd_d  = '0;
    if (soft_clr)                            rd_d = '0;
    else if (!rd_in_range)                   rd_d = '0;
    else if (ridx == BANK_W'(IDX_EN0))       rd_d = en_q[0];
    else if (ridx == BANK_W'(IDX_EN1))       rd_d = en_q[1];
    else                                     rd_d = bank_word;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n)   bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_d;
  end

  a_r1_oor_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_rd && (bus_raddr >= ADDR_W'(NUM_WORDS * 4)) |=> bus_rdata == '0);
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    !bus_rd && !soft_clr |=> $stable(bus_rdata));
  a_r8_self_rst: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_wr && bus_waddr == ADDR_W'(IDX_CMD * 4) &&
    (bus_wdata[CMD_BIT_FULL] || bus_wdata[CMD_BIT_ERR])
    |=> bus_rdata == '0 && en_q == '0);
  a_r6_alias_zero: assert property (@(posedge clk) disable iff (!rst_i_n)
    bus_rd && !soft_clr && (bus_raddr[ADDR_W-1:2] >= (ADDR_W-2)'(IDX_SET0)) &&
    (bus_raddr[ADDR_W-1:2] <= (ADDR_W-2)'(IDX_CLR1)) |=> bus_rdata == '0);
endmodule

// File: tb/psi_port_regs_tb.sv
module psi_port_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr, bus_rd;
  logic [11:0] bus_waddr, bus_raddr;
  logic [31:0] bus_wdata, bus_rdata;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  always #5 clk = ~clk;

  psi_port_regs u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_waddr(bus_waddr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_raddr(bus_raddr),
    .bus_rdata(bus_rdata)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %08h expected %08h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_waddr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_raddr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic t_reset_values;
    rd_chk("R9 version", 12'h074, 32'hE005_0101);
    rd_chk("R9 en0", 12'h010, 32'h0);
    rd_chk("R9 en1", 12'h014, 32'h0);
    rd_chk("R9 word0", 12'h000, 32'h0);
    rd_chk("R9 top word", 12'h1FC, 32'h0);
  endtask

  task automatic t_plain_store;
    wr(12'h000, 32'hA5A5_5A5A);
    wr(12'h1FC, 32'h1234_5678);
    wr(12'h074, 32'hCAFE_F00D);
    rd_chk("R10 word0", 12'h000, 32'hA5A5_5A5A);
    rd_chk("R10 top word", 12'h1FC, 32'h1234_5678);
    rd_chk("R10 version writable", 12'h074, 32'hCAFE_F00D);
  endtask

  task automatic t_index_and_range;
    wr(12'h043, 32'h0BAD_F00D);
    rd_chk("R1 low bits ignored", 12'h040, 32'h0BAD_F00D);
    wr(12'h200, 32'hDEAD_BEEF);
    rd_chk("R1 oor read", 12'h200, 32'h0);
    rd_chk("R1 oor no alias", 12'h000, 32'hA5A5_5A5A);
    rd_chk("R1 oor high", 12'hFFC, 32'h0);
  endtask

  task automatic t_enables;
    wr(12'h010, 32'hF0F0_0F0F);
    wr(12'h014, 32'h1234_5678);
    rd_chk("R3 en0 load", 12'h010, 32'hF0F0_0F0F);
    rd_chk("R3 en1 load", 12'h014, 32'h1234_5678);
    wr(12'h018, 32'h0000_00F0);
    wr(12'h01C, 32'h8000_0001);
    rd_chk("R4 en0 set", 12'h010, 32'hF0F0_0FFF);
    rd_chk("R4 en1 set", 12'h014, 32'h9234_5679);
    wr(12'h020, 32'hF000_000F);
    wr(12'h024, 32'hFFFF_0000);
    rd_chk("R5 en0 clear", 12'h010, 32'h00F0_0FF0);
    rd_chk("R5 en1 clear", 12'h014, 32'h0000_5679);
    rd_chk("R6 set0 reads 0", 12'h018, 32'h0);
    rd_chk("R6 set1 reads 0", 12'h01C, 32'h0);
    rd_chk("R6 clr0 reads 0", 12'h020, 32'h0);
    rd_chk("R6 clr1 reads 0", 12'h024, 32'h0);
  endtask

  task automatic t_err_and_cmd_noop;
    wr(12'h0D0, 32'hFFFF_FFFF);
    rd_chk("R7 err reads 0", 12'h0D0, 32'h0);
    wr(12'h1D0, 32'h3FFF_FFFF);
    rd_chk("R8 no-op keeps en0", 12'h010, 32'h00F0_0FF0);
    rd_chk("R8 no-op keeps word", 12'h000, 32'hA5A5_5A5A);
    rd_chk("R8 cmd reads 0", 12'h1D0, 32'h0);
  endtask

  task automatic t_rw_same_edge;
    logic [31:0] v;
    wr(12'h080, 32'h0000_0111);
    @(negedge clk);
    bus_rd = 1'b1; bus_raddr = 12'h080;
    bus_wr = 1'b1; bus_waddr = 12'h080; bus_wdata = 32'h0000_0222;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    chk("R2 read sees old", bus_rdata, 32'h0000_0111);
    repeat (3) @(negedge clk);
    chk("R2 rdata holds", bus_rdata, 32'h0000_0111);
    rd(12'h080, v);
    chk("R2 read sees new", v, 32'h0000_0222);
  endtask

  task automatic t_self_reset_vs_read;
    @(negedge clk);
    bus_rd = 1'b1; bus_raddr = 12'h010;
    bus_wr = 1'b1; bus_waddr = 12'h1D0; bus_wdata = 32'h8000_0000;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    chk("R8 reset beats read", bus_rdata, 32'h0);
    rd_chk("R8 en0 cleared", 12'h010, 32'h0);
    rd_chk("R8 en1 cleared", 12'h014, 32'h0);
    rd_chk("R8 word cleared", 12'h000, 32'h0);
    rd_chk("R9 version restored", 12'h074, 32'hE005_0101);
    wr(12'h080, 32'h5555_AAAA);
    wr(12'h014, 32'h0000_00FF);
    wr(12'h1D0, 32'h4000_0000);
    rd_chk("R8 bit30 clears word", 12'h080, 32'h0);
    rd_chk("R8 bit30 clears en1", 12'h014, 32'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_waddr = '0; bus_raddr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 rdata reset", bus_rdata, 32'h0);
    t_reset_values();
    t_plain_store();
    t_index_and_range();
    t_enables();
    t_err_and_cmd_noop();
    t_rw_same_edge();
    t_self_reset_vs_read();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule